// File: doc/BRIEF.md
# Indexed Color Palette Store with Register Access

This block keeps a color lookup table and the few extra colors a display needs besides it: two cursor colors and a border (overscan) color. A host reaches all of them through two words on a 32-bit register bus. The first word is an index register. The second is a data window. The host loads an index once and then streams data reads or data writes. Each data access uses the entry the index points at, and the index then moves one step forward by itself. A long block of entries therefore needs only one index load. Loading a new index is needed only when the host jumps to a new place.

The index space is 9 bits wide. The lower half holds the 256 table colors. The upper half holds the extension colors at fixed positions. The positions between and above them are holes that store nothing.

A display-side port turns an 8-bit pixel value into a color one clock later. The block also drives the two cursor colors and the border color at all times. A format input chooses what these display outputs show: the full 24-bit color, or the color cut down to 5:6:5 or 5:5:5 precision with the dropped low bits of each component forced to zero.

Top module: `palette_port`

## Requirements
- R1: A write to byte offset 070h loads bits 8:0 of the write data into the 9-bit index and ignores bits 31:9. A read of 070h returns the index in bits 8:0, and bits 31:9 read as zero. Accesses to 070h never change the index by themselves stepping.
- R2: Every read or write of the data window at byte offset 074h advances the index by one after the access. The index wraps from 1FFh to 000h.
- R3: Indices 000h to 0FFh select the 256 table entries. The color travels in bits 23:0 of the data window. Write bits 31:24 are ignored, and read bits 31:24 return zero.
- R4: Index 100h is cursor color 0, index 101h is cursor color 1, and index 104h is the border color. Each can be written and read back through the data window.
- R5: Indices 102h, 103h and 105h to 1FFh are holes. A write to a hole changes no stored color, a read from a hole returns zero, and the index still advances.
- R6: The read data output is registered. It updates on the clock edge where the read strobe is sampled and holds until the next read. A read of any offset other than 070h or 074h returns zero, and a write to such an offset changes nothing. When the read and write strobes are high in the same cycle, only the write takes place and the read data output keeps its value.
- R7: The pixel color output shows the table entry that the pixel index selected at the previous clock edge. It is formatted with the format input of the current cycle. A host write to the same entry in that same cycle is not yet visible.
- R8: The cursor 0, cursor 1 and border outputs always show the stored extension colors, formatted with the current format input. After a write, they change at the clock edge that completes the write.
- R9: Format code 0 (and code 3) gives the full 24-bit color. Code 1 gives 5:6:5: red bits 23:19, green bits 15:10 and blue bits 7:3 are kept, and all other bits are zero. Code 2 gives 5:5:5: bits 23:19, 15:11 and 7:3 are kept, and all other bits are zero.
- R10: Reset clears the index, the three extension colors and the read data output to zero. Table entries hold no defined value until they are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| pix_idx | input | 8 | Pixel value to look up |
| fmt_mode | input | 2 | Display output format code |
| pix_color | output | 24 | Looked-up pixel color, one cycle latency |
| cursor0_color | output | 24 | Formatted cursor color 0 |
| cursor1_color | output | 24 | Formatted cursor color 1 |
| overscan_color | output | 24 | Formatted border color |

## Verification
An index that has slipped or failed to wrap shows up at the very next data-window read. That read returns the color of a neighbouring entry, and every later access in the same run is shifted by the same amount. The index itself can be read back at any time to pin the fault down to a single access. A hole decoded as storage gets caught right after the write that should have been dropped: a hole read returns nonzero, or one of the always-on extension outputs changes. A fault in the pixel path or the format masking appears one clock after the pixel index is presented, so stimulus and response pair up cycle by cycle.

// File: rtl/palette_pkg.sv
package palette_pkg;

  localparam int IDX_W   = 9;
  localparam int COLOR_W = 24;
  localparam int STD_N   = 1 << (IDX_W - 1);
  localparam int EXT_N   = 3;

  typedef enum logic [2:0] {
    SLOT_STD  = 3'd0,
    SLOT_CUR0 = 3'd1,
    SLOT_CUR1 = 3'd2,
    SLOT_OVS  = 3'd3,
    SLOT_NONE = 3'd4
  } slot_e;

  typedef enum logic [1:0] {
    FMT_FULL  = 2'd0,
    FMT_565   = 2'd1,
    FMT_555   = 2'd2,
    FMT_FULL2 = 2'd3
  } fmt_e;

  // Map a 9-bit index onto the storage slot it reaches.
  function automatic slot_e classify(input logic [IDX_W-1:0] idx);
    slot_e s;
    if (!idx[IDX_W-1]) begin
      s = SLOT_STD;
    end else begin
      case (idx[IDX_W-2:0])
        8'h00:   s = SLOT_CUR0;
        8'h01:   s = SLOT_CUR1;
        8'h04:   s = SLOT_OVS;
        default: s = SLOT_NONE;
      endcase
    end
    return s;
  endfunction

  // Bits kept by each display format.
  function automatic logic [COLOR_W-1:0] fmt_mask(input fmt_e m);
    logic [COLOR_W-1:0] k;
    case (m)
      FMT_565: k = 24'hF8FCF8;
      FMT_555: k = 24'hF8F8F8;
      default: k = 24'hFFFFFF;
    endcase
    return k;
  endfunction

  function automatic logic [COLOR_W-1:0] apply_fmt(input logic [COLOR_W-1:0] c,
                                                   input fmt_e m);
    return c & fmt_mask(m);
  endfunction

endpackage

// File: rtl/pal_index_reg.sv
module pal_index_reg #(
  parameter int IW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [IW-1:0] load_val,
  input  logic          step,
  output logic [IW-1:0] idx
);
  localparam logic [IW-1:0] ONE = IW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (load) begin
      idx <= load_val;
    end else if (step) begin
      idx <= idx + ONE;
    end
  end
endmodule

// File: rtl/pal_store.sv
module pal_store
  import palette_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          host_we,
  input  logic [IDX_W-1:0]              host_idx,
  input  logic [COLOR_W-1:0]            host_wdata,
  output logic [COLOR_W-1:0]            host_rcolor,
  output logic                          host_hole,
  input  logic [IDX_W-2:0]              pix_idx,
  output logic [COLOR_W-1:0]            pix_raw_q,
  output logic [EXT_N-1:0][COLOR_W-1:0] ext_raw
);
  slot_e host_slot;
  logic [COLOR_W-1:0] std_mem [STD_N];

  assign host_slot = classify(host_idx);
  assign host_hole = (host_slot == SLOT_NONE);

  always_ff @(posedge clk) begin
    if (host_we && host_slot == SLOT_STD) begin
      std_mem[host_idx[IDX_W-2:0]] <= host_wdata;
    end
    pix_raw_q <= std_mem[pix_idx];
  end

  // One register per extension slot; slot g+1 in the enum.
  genvar g;
  generate
    for (g = 0; g < EXT_N; g++) begin : g_ext
      logic hit;
      assign hit = host_we && (host_slot == slot_e'(g + 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   ext_raw[g] <= '0;
        else if (hit) ext_raw[g] <= host_wdata;
      end
    end
  endgenerate

  always_comb begin
    case (host_slot)
      SLOT_STD:  host_rcolor = std_mem[host_idx[IDX_W-2:0]];
      SLOT_CUR0: host_rcolor = ext_raw[0];
      SLOT_CUR1: host_rcolor = ext_raw[1];
      SLOT_OVS:  host_rcolor = ext_raw[2];
      default:   host_rcolor = '0;
    endcase
  end
endmodule

// File: rtl/pal_fmt.sv
module pal_fmt
  import palette_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0][COLOR_W-1:0] raw_in,
  input  logic [1:0]                mode,
  output logic [N-1:0][COLOR_W-1:0] fmt_out
);
  fmt_e m;
  assign m = fmt_e'(mode);

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_lane
      assign fmt_out[g] = apply_fmt(raw_in[g], m);
    end
  endgenerate
endmodule

// File: rtl/palette_port.sv
module palette_port
  import palette_pkg::*;
#(
  parameter int                REG_AW   = 8,
  parameter int                REG_DW   = 32,
  parameter logic [REG_AW-1:0] IDX_OFS  = 8'h70,
  parameter logic [REG_AW-1:0] DATA_OFS = 8'h74
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [REG_DW-1:0]   reg_wdata,
  output logic [REG_DW-1:0]   reg_rdata,
  input  logic [IDX_W-2:0]    pix_idx,
  input  logic [1:0]          fmt_mode,
  output logic [COLOR_W-1:0]  pix_color,
  output logic [COLOR_W-1:0]  cursor0_color,
  output logic [COLOR_W-1:0]  cursor1_color,
  output logic [COLOR_W-1:0]  overscan_color
);
  localparam int NLANE = EXT_N + 1;

  // Named internal events.
  logic                 rd_eff;
  logic                 idx_load;
  logic                 idx_read;
  logic                 data_wr;
  logic                 data_rd;
  logic                 data_acc;
  logic [IDX_W-1:0]     load_val;
  logic [IDX_W-1:0]     idx_q;
  logic [COLOR_W-1:0]   wdata_color;
  logic [COLOR_W-1:0]   host_rcolor;
  logic                 host_hole;
  logic [COLOR_W-1:0]   pix_raw_q;
  logic [EXT_N-1:0][COLOR_W-1:0] ext_raw;
  logic [NLANE-1:0][COLOR_W-1:0] lane_raw;
  logic [NLANE-1:0][COLOR_W-1:0] lane_fmt;
  logic [REG_DW-1:0]    rdata_d;
  logic                 unused_wbits;

  assign rd_eff      = reg_rd && !reg_wr;
  assign idx_load    = reg_wr && (reg_addr == IDX_OFS);
  assign idx_read    = rd_eff && (reg_addr == IDX_OFS);
  assign data_wr     = reg_wr && (reg_addr == DATA_OFS);
  assign data_rd     = rd_eff && (reg_addr == DATA_OFS);
  assign data_acc    = data_wr || data_rd;
  assign load_val    = reg_wdata[IDX_W-1:0];
  assign wdata_color = reg_wdata[COLOR_W-1:0];
  assign unused_wbits = ^reg_wdata[REG_DW-1:COLOR_W];

  pal_index_reg #(.IW(IDX_W)) u_idx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (idx_load),
    .load_val (load_val),
    .step     (data_acc),
    .idx      (idx_q)
  );

  pal_store u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_we     (data_wr),
    .host_idx    (idx_q),
    .host_wdata  (wdata_color),
    .host_rcolor (host_rcolor),
    .host_hole   (host_hole),
    .pix_idx     (pix_idx),
    .pix_raw_q   (pix_raw_q),
    .ext_raw     (ext_raw)
  );

  assign lane_raw[0] = pix_raw_q;
  assign lane_raw[1] = ext_raw[0];
  assign lane_raw[2] = ext_raw[1];
  assign lane_raw[3] = ext_raw[2];

  pal_fmt #(.N(NLANE)) u_fmt (
    .raw_in  (lane_raw),
    .mode    (fmt_mode),
    .fmt_out (lane_fmt)
  );

  assign pix_color      = lane_fmt[0];
  assign cursor0_color  = lane_fmt[1];
  assign cursor1_color  = lane_fmt[2];
  assign overscan_color = lane_fmt[3];

  always_comb begin
    rdata_d = '0;
    if (idx_read)     rdata_d[IDX_W-1:0]   = idx_q;
    else if (data_rd) rdata_d[COLOR_W-1:0] = host_rcolor;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (rd_eff) reg_rdata <= rdata_d;
  end
endmodule

// File: rtl/palette_port_chk.sv
module palette_port_chk #(
  parameter int IW = 9,
  parameter int CW = 24,
  parameter int DW = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                data_acc,
  input logic                data_wr,
  input logic                data_rd,
  input logic                idx_load,
  input logic                host_hole,
  input logic [IW-1:0]       idx_q,
  input logic [IW-1:0]       load_val,
  input logic [CW-1:0]       wdata_color,
  input logic [3*CW-1:0]     ext_flat,
  input logic [DW-1:0]       reg_rdata
);
  localparam logic [IW-1:0] CUR0_IDX = IW'(9'h100);

  // R1
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_load |=> idx_q == $past(load_val));

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |=> idx_q == IW'($past(idx_q) + IW'(1)));

  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_acc && !idx_load) |=> $stable(idx_q));

  // R3
  data_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd |=> reg_rdata[DW-1:CW] == '0);

  // R4
  cur0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && idx_q == CUR0_IDX) |=> ext_flat[CW-1:0] == $past(wdata_color));

  // R5
  hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && host_hole) |=> reg_rdata == '0);

  // R5
  hole_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && host_hole) |=> $stable(ext_flat));
endmodule

bind palette_port palette_port_chk #(
  .IW(palette_pkg::IDX_W), .CW(palette_pkg::COLOR_W), .DW(REG_DW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .data_acc    (data_acc),
  .data_wr     (data_wr),
  .data_rd     (data_rd),
  .idx_load    (idx_load),
  .host_hole   (host_hole),
  .idx_q       (idx_q),
  .load_val    (load_val),
  .wdata_color (wdata_color),
  .ext_flat    (ext_raw),
  .reg_rdata   (reg_rdata)
);

// File: tb/tb_palette_port.sv
`timescale 1ns/1ps
module tb_palette_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  pix_idx = '0;
  logic [1:0]  fmt_mode = '0;
  logic [23:0] pix_color, cursor0_color, cursor1_color, overscan_color;

  always #2.5 clk = ~clk;

  palette_port dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pix_idx(pix_idx), .fmt_mode(fmt_mode), .pix_color(pix_color),
    .cursor0_color(cursor0_color), .cursor1_color(cursor1_color),
    .overscan_color(overscan_color)
  );

  localparam logic [7:0] A_IDX = 8'h70;
  localparam logic [7:0] A_DAT = 8'h74;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [23:0] m_std [256];
  logic [23:0] m_c0 = '0, m_c1 = '0, m_ovs = '0;
  logic [8:0]  m_idx = '0;

  function automatic logic [23:0] exp_fmt(input logic [23:0] c, input logic [1:0] m);
    case (m)
      2'd1:    return {c[23:19], 3'b000, c[15:10], 2'b00, c[7:3], 3'b000};
      2'd2:    return {c[23:19], 3'b000, c[15:11], 3'b000, c[7:3], 3'b000};
      default: return c;
    endcase
  endfunction

  function automatic logic [23:0] model_rd(input logic [8:0] i);
    if (i < 9'h100)  return m_std[i[7:0]];
    if (i == 9'h100) return m_c0;
    if (i == 9'h101) return m_c1;
    if (i == 9'h104) return m_ovs;
    return 24'h0;
  endfunction

  task automatic model_wr(input logic [8:0] i, input logic [23:0] c);
    if (i < 9'h100)       m_std[i[7:0]] = c;
    else if (i == 9'h100) m_c0 = c;
    else if (i == 9'h101) m_c1 = c;
    else if (i == 9'h104) m_ovs = c;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic set_idx(input logic [8:0] i);
    bus_wr(A_IDX, {$urandom() & 32'hFFFFFE00} | {23'h0, i});
    m_idx = i;
  endtask

  task automatic data_write(input logic [31:0] d);
    bus_wr(A_DAT, d);
    model_wr(m_idx, d[23:0]);
    m_idx = m_idx + 9'd1;
  endtask

  task automatic data_read_chk(input string req);
    logic [31:0] d;
    bus_rd(A_DAT, d);
    chk(req, d, {8'h0, model_rd(m_idx)});
    m_idx = m_idx + 9'd1;
  endtask

  task automatic idx_chk(input string req);
    logic [31:0] d;
    bus_rd(A_IDX, d);
    chk(req, d, {23'h0, m_idx});
  endtask

  task automatic ext_chk(input string req);
    chk(req, {8'h0, cursor0_color},  {8'h0, exp_fmt(m_c0, fmt_mode)});
    chk(req, {8'h0, cursor1_color},  {8'h0, exp_fmt(m_c1, fmt_mode)});
    chk(req, {8'h0, overscan_color}, {8'h0, exp_fmt(m_ovs, fmt_mode)});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5.0);
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d, prev;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    chk("R10 rdata", reg_rdata, 32'h0);
    ext_chk("R10 ext");
    idx_chk("R10 idx");

    // R1: reserved index bits ignored
    bus_wr(A_IDX, 32'hFFFF_FE05); m_idx = 9'h005;
    idx_chk("R1 reserved bits");

    // R3 R2: fill table through auto-increment
    set_idx(9'h000);
    for (int k = 0; k < 256; k++) data_write($urandom());
    idx_chk("R2 after fill");
    set_idx(9'h0FC);
    for (int k = 0; k < 4; k++) data_read_chk("R3 readback");

    // R3: upper write bits dropped, upper read bits zero
    set_idx(9'h033);
    data_write(32'hAB12_3456);
    set_idx(9'h033);
    data_read_chk("R3 upper bits");

    // R4 R5 R8: extension and hole writes, 100h..104h
    set_idx(9'h0FF);
    for (int k = 0; k < 6; k++) data_write($urandom());
    ext_chk("R8 after ext write");
    set_idx(9'h100);
    for (int k = 0; k < 5; k++) data_read_chk("R4 R5 ext/hole read");

    // R5 R2: hole writes ignored, wrap at 1FFh
    set_idx(9'h1FE);
    data_write(32'h00C0FFEE);
    data_write(32'h00BADBAD);
    idx_chk("R2 wrap");
    ext_chk("R5 hole write no effect");
    set_idx(9'h1FF);
    data_read_chk("R5 hole read");
    idx_chk("R2 wrap on read");
    data_read_chk("R5 entry0 unchanged");

    // R6: other offsets
    set_idx(9'h010);
    bus_wr(8'h78, 32'h0000_0077);
    idx_chk("R6 stray write");
    bus_rd(8'h78, d);
    chk("R6 stray read", d, 32'h0);

    // R6: both strobes, write wins
    set_idx(9'h020);
    bus_rd(A_IDX, prev);
    @(negedge clk);
    reg_wr = 1'b1; reg_rd = 1'b1; reg_addr = A_DAT; reg_wdata = 32'h0012_ABCD;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    chk("R6 read suppressed", reg_rdata, prev);
    model_wr(9'h020, 24'h12ABCD); m_idx = 9'h021;
    idx_chk("R6 single step");
    set_idx(9'h020);
    data_read_chk("R6 write taken");

    // R7 R9 R8: display path
    for (int k = 0; k < 300; k++) begin
      logic [7:0] pi;
      @(negedge clk);
      pi = (k < 8) ? 8'(k * 37) : 8'($urandom());
      pix_idx = pi;
      fmt_mode = 2'($urandom());
      @(negedge clk);
      chk("R7 R9 pixel", {8'h0, pix_color}, {8'h0, exp_fmt(m_std[pi], fmt_mode)});
      if (k % 25 == 0) ext_chk("R8 R9 ext fmt");
    end

    // R7: same-cycle write is not yet visible on pixel path
    set_idx(9'h044);
    fmt_mode = 2'd0;
    prev = {8'h0, m_std[8'h44]};
    @(negedge clk);
    pix_idx = 8'h44;
    reg_wr = 1'b1; reg_addr = A_DAT; reg_wdata = 32'h0055_6677;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R7 old value", {8'h0, pix_color}, prev);
    model_wr(9'h044, 24'h556677); m_idx = 9'h045;
    @(negedge clk);
    chk("R7 new value", {8'h0, pix_color}, 32'h0055_6677);

    // Random mixed host traffic, all requirements R1 R2 R3 R4 R5
    for (int k = 0; k < 400; k++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op == 0) begin
        case ($urandom_range(0, 3))
          0: set_idx(9'h0FE);
          1: set_idx(9'h1FD);
          2: set_idx(9'h102);
          default: set_idx(9'($urandom()));
        endcase
      end else if (op < 4) data_write($urandom());
      else if (op < 9) data_read_chk("R2 R3 R4 R5 random read");
      else idx_chk("R1 random idx");
    end
    ext_chk("R8 final");

    finish_run();
  end
endmodule